// File: doc/BRIEF.md
# Multiplexed Bus Trace Capture Unit

The unit watches a 32-bit processor bus that carries address and data on the same pins, and it writes one trace entry for each word that crosses the bus. Every bus input is first brought into the trace clock domain through two-flop synchronizers. Edges on the strobes are then detected as single-cycle pulses.

A read word is captured each time the read-data-enable strobe is asserted, so a four-word burst gives exactly four entries. A write is captured when WR returns high. The diagnostic pins are time-multiplexed, so they are latched when ALE is asserted. Those latched values set the transaction type of every word that follows.

If the read-data-enable strobe pulses while a write is in progress, no read entry is made. Instead, the next store entry is flagged as a trigger error. Entries are held in a 16-entry trace buffer and leave on a valid/ready stream. When the buffer is full, new entries are dropped and counted.

Top module: `trc_capture`

## Requirements
- R1: After reset `ent_valid_o` is 0 and `ovf_cnt_o` is 0.
- R2: While `rd_ni` is low and `wr_ni` is high, each assertion (high-to-low) of `rden_ni` records exactly one entry. Its data is the value of `ad_i` at that moment. Holding `rd_ni` low adds no entries, so a four-pulse burst gives four entries.
- R3: A read entry's address is {upper address latched at ALE, beat, 2'b00}. The beat starts at the `addr_lo_i` value latched at ALE and increments by one (modulo 4) after each captured read word.
- R4: `diag1_i` and `diag0_i` are latched when `ale_ni` falls, and later changes on those pins have no effect. A read is typed 2'b00 (uncached load) when the latched diag1 is 0, whatever diag0 is. It is typed 2'b01 (data load) for diag1=1 with diag0=0, and 2'b10 (instruction fetch) for diag1=1 with diag0=1.
- R5: A rising edge of `wr_ni` records a store entry. The entry has type 2'b11, data equal to `ad_i` at that moment, and address {latched upper address, latched `addr_lo_i`, 2'b00}. Its `ent_wr_cached_o` equals the latched diag1, and the latched diag0 is ignored.
- R6: A `rden_ni` assertion while `wr_ni` is low records no read entry. It sets `ent_trig_err_o` on the store entry that follows.
- R7: Entries leave in capture order. While `ent_valid_o` is high and `ent_ready_i` is low, the presented entry stays unchanged.
- R8: The buffer holds 16 entries. When it is full, the stored entries are kept and each new entry is dropped. Every dropped entry increments `ovf_cnt_o`, which saturates at its maximum.
- R9: Entries that are not stores always carry `ent_wr_cached_o`=0 and `ent_trig_err_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Trace clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ad_i | input | 32 | Multiplexed address/data bus |
| addr_hi_i | input | 28 | Externally latched address bits 31:4 |
| addr_lo_i | input | 2 | Address bits 3:2 |
| rd_ni | input | 1 | Read cycle, active low |
| wr_ni | input | 1 | Write cycle, active low |
| rden_ni | input | 1 | Read-data-enable strobe, active low |
| ale_ni | input | 1 | Address latch enable, active low |
| diag1_i | input | 1 | Diagnostic pin 1 (cacheable / retained on write) |
| diag0_i | input | 1 | Diagnostic pin 0 (fetch vs data) |
| ent_valid_o | output | 1 | Trace entry available |
| ent_ready_i | input | 1 | Consumer accepts entry |
| ent_addr_o | output | 32 | Entry word address |
| ent_data_o | output | 32 | Entry data |
| ent_kind_o | output | 2 | Entry type (00 uncached, 01 data load, 10 fetch, 11 store) |
| ent_wr_cached_o | output | 1 | Store data retained in data cache |
| ent_trig_err_o | output | 1 | Store saw a spurious read-enable strobe |
| ovf_cnt_o | output | 8 | Dropped-entry count |

## Verification
The bench drives four-pulse bursts, and a design that captured on RD or on the level of the strobe would emit missing or duplicated words. It starts a burst at beat 2 so that a missing modulo-4 wrap would show up as a wrong address. It also flips the diagnostic pins right after ALE, so a design that decoded the live pins would mistype the entries. A read-enable pulse is injected during a store, and any stray read entry or missing error flag is caught by the scoreboard. Finally, 18 stores are pushed into a stalled consumer: a buffer that overwrote old entries or miscounted drops would deliver the wrong first sixteen entries or the wrong overflow count.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BEAT_W = 2;
  localparam int unsigned HI_W   = ADDR_W - BEAT_W - 2;

  typedef enum logic [1:0] {
    KIND_UNC = 2'b00,
    KIND_DLD = 2'b01,
    KIND_IFT = 2'b10,
    KIND_ST  = 2'b11
  } trc_kind_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    trc_kind_e         kind;
    logic              wr_cached;
    logic              trig_err;
  } trc_entry_t;
endpackage

// File: rtl/trc_sync.sv
module trc_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/trc_decode.sv
module trc_decode
  import trc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic              rden_n_i,
  input  logic              ale_n_i,
  input  logic              diag1_i,
  input  logic              diag0_i,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [HI_W-1:0]   hi_i,
  input  logic [BEAT_W-1:0] lo_i,
  output logic              push_o,
  output trc_entry_t        entry_o
);
  logic rden_q, wr_q, ale_q;
  logic rden_fall, wr_rise, ale_fall, rd_cap, spur_set;
  logic [HI_W-1:0]   hi_q;
  logic [BEAT_W-1:0] lo_q, beat_q;
  logic d1_q, d0_q, spur_q;
  trc_kind_e rd_kind;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rden_q <= 1'b1;
      wr_q   <= 1'b1;
      ale_q  <= 1'b1;
    end else begin
      rden_q <= rden_n_i;
      wr_q   <= wr_n_i;
      ale_q  <= ale_n_i;
    end
  end

  assign rden_fall = rden_q & ~rden_n_i;
  assign wr_rise   = ~wr_q & wr_n_i;
  assign ale_fall  = ale_q & ~ale_n_i;
  assign rd_cap    = rden_fall & ~rd_n_i & wr_n_i;
  assign spur_set  = rden_fall & ~wr_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      lo_q   <= '0;
      beat_q <= '0;
      d1_q   <= 1'b0;
      d0_q   <= 1'b0;
      spur_q <= 1'b0;
    end else if (ale_fall) begin
      hi_q   <= hi_i;
      lo_q   <= lo_i;
      beat_q <= lo_i;
      d1_q   <= diag1_i;
      d0_q   <= diag0_i;
      spur_q <= 1'b0;
    end else begin
      if (rd_cap) beat_q <= beat_q + BEAT_W'(1);
      if (spur_set)     spur_q <= 1'b1;
      else if (wr_rise) spur_q <= 1'b0;
    end
  end

  always_comb begin
    if (!d1_q)     rd_kind = KIND_UNC;
    else if (d0_q) rd_kind = KIND_IFT;
    else           rd_kind = KIND_DLD;
  end

  // store wins if both strobes land in one cycle
  always_comb begin
    entry_o.data = ad_i;
    if (wr_rise) begin
      entry_o.addr      = {hi_q, lo_q, 2'b00};
      entry_o.kind      = KIND_ST;
      entry_o.wr_cached = d1_q;
      entry_o.trig_err  = spur_q | spur_set;
    end else begin
      entry_o.addr      = {hi_q, beat_q, 2'b00};
      entry_o.kind      = rd_kind;
      entry_o.wr_cached = 1'b0;
      entry_o.trig_err  = 1'b0;
    end
  end

  assign push_o = wr_rise | rd_cap;
endmodule

// File: rtl/trc_fifo.sv
module trc_fifo
  import trc_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned OVF_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  trc_entry_t       entry_i,
  output logic             valid_o,
  input  logic             ready_i,
  output trc_entry_t       entry_o,
  output logic             full_o,
  output logic [OVF_W-1:0] ovf_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  trc_entry_t    mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [AW:0]   cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == FULL_CNT);
  assign valid_o = (cnt_q != '0);
  assign do_pop  = valid_o & ready_i;
  assign do_push = push_i & ~full_o;
  assign entry_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      ovf_o    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (do_pop)  rd_ptr_q <= rd_ptr_q + AW'(1);
      if (do_push && !do_pop)      cnt_q <= cnt_q + (AW+1)'(1);
      else if (!do_push && do_pop) cnt_q <= cnt_q - (AW+1)'(1);
      if (push_i && full_o && ovf_o != '1) ovf_o <= ovf_o + OVF_W'(1);
    end
  end
endmodule

// File: rtl/trc_capture.sv
module trc_capture
  import trc_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned OVF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] ad_i,
  input  logic [HI_W-1:0]   addr_hi_i,
  input  logic [BEAT_W-1:0] addr_lo_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic              rden_ni,
  input  logic              ale_ni,
  input  logic              diag1_i,
  input  logic              diag0_i,
  output logic              ent_valid_o,
  input  logic              ent_ready_i,
  output logic [ADDR_W-1:0] ent_addr_o,
  output logic [DATA_W-1:0] ent_data_o,
  output logic [1:0]        ent_kind_o,
  output logic              ent_wr_cached_o,
  output logic              ent_trig_err_o,
  output logic [OVF_W-1:0]  ovf_cnt_o
);
  localparam int unsigned BUS_W = DATA_W + HI_W + BEAT_W;

  logic [5:0]       ctl_s;
  logic [BUS_W-1:0] bus_s;
  logic             cap_push, buf_full;
  trc_entry_t       cap_entry, out_entry;

  trc_sync #(.W(6), .RST_VAL(6'b111100)) u_sync_ctl (
    .clk_i, .rst_ni,
    .d_i({ale_ni, rden_ni, wr_ni, rd_ni, diag1_i, diag0_i}),
    .q_o(ctl_s)
  );

  // data path delayed to match the strobe synchronizers
  trc_sync #(.W(BUS_W), .RST_VAL('0)) u_sync_bus (
    .clk_i, .rst_ni,
    .d_i({ad_i, addr_hi_i, addr_lo_i}),
    .q_o(bus_s)
  );

  trc_decode u_decode (
    .clk_i, .rst_ni,
    .rd_n_i  (ctl_s[2]),
    .wr_n_i  (ctl_s[3]),
    .rden_n_i(ctl_s[4]),
    .ale_n_i (ctl_s[5]),
    .diag1_i (ctl_s[1]),
    .diag0_i (ctl_s[0]),
    .ad_i    (bus_s[BUS_W-1 -: DATA_W]),
    .hi_i    (bus_s[BEAT_W +: HI_W]),
    .lo_i    (bus_s[BEAT_W-1:0]),
    .push_o  (cap_push),
    .entry_o (cap_entry)
  );

  trc_fifo #(.DEPTH(DEPTH), .OVF_W(OVF_W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i (cap_push),
    .entry_i(cap_entry),
    .valid_o(ent_valid_o),
    .ready_i(ent_ready_i),
    .entry_o(out_entry),
    .full_o (buf_full),
    .ovf_o  (ovf_cnt_o)
  );

  assign ent_addr_o      = out_entry.addr;
  assign ent_data_o      = out_entry.data;
  assign ent_kind_o      = out_entry.kind;
  assign ent_wr_cached_o = out_entry.wr_cached;
  assign ent_trig_err_o  = out_entry.trig_err;
endmodule

// File: rtl/trc_capture_chk.sv
module trc_capture_chk #(
  parameter int unsigned OVF_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ent_valid_o,
  input logic             ent_ready_i,
  input logic [31:0]      ent_addr_o,
  input logic [31:0]      ent_data_o,
  input logic [1:0]       ent_kind_o,
  input logic             ent_wr_cached_o,
  input logic             ent_trig_err_o,
  input logic [OVF_W-1:0] ovf_cnt_o,
  input logic             cap_push,
  input logic             buf_full
);
  // R7
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_valid_o && !ent_ready_i |=> ent_valid_o && $stable(ent_addr_o)
      && $stable(ent_data_o) && $stable(ent_kind_o));

  // R8
  ovf_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_push && buf_full && ovf_cnt_o != '1 |=> ovf_cnt_o == $past(ovf_cnt_o) + OVF_W'(1));

  // R8
  ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cap_push && buf_full) |=> $stable(ovf_cnt_o));

  // R9
  read_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ent_valid_o && ent_kind_o != 2'b11 |-> !ent_wr_cached_o && !ent_trig_err_o);
endmodule

bind trc_capture trc_capture_chk #(.OVF_W(OVF_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .ent_valid_o(ent_valid_o), .ent_ready_i(ent_ready_i),
  .ent_addr_o(ent_addr_o), .ent_data_o(ent_data_o),
  .ent_kind_o(ent_kind_o), .ent_wr_cached_o(ent_wr_cached_o),
  .ent_trig_err_o(ent_trig_err_o), .ovf_cnt_o(ovf_cnt_o),
  .cap_push(cap_push), .buf_full(buf_full)
);

// File: tb/trc_capture_tb.sv
`timescale 1ns/1ps
module trc_capture_tb;
  import trc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] ad = '0;
  logic [27:0] hi = '0;
  logic [1:0]  lo = '0;
  logic        rd_n = 1'b1, wr_n = 1'b1, rden_n = 1'b1, ale_n = 1'b1;
  logic        d1 = 1'b0, d0 = 1'b0;
  logic        ready = 1'b1;
  logic        valid, wrc, terr;
  logic [31:0] e_addr, e_data;
  logic [1:0]  e_kind;
  logic [7:0]  ovf;

  int checks = 0, errors = 0;
  bit done = 0;
  trc_entry_t exp_q[$];

  always #4 clk = ~clk;

  trc_capture u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .ad_i(ad), .addr_hi_i(hi), .addr_lo_i(lo),
    .rd_ni(rd_n), .wr_ni(wr_n), .rden_ni(rden_n), .ale_ni(ale_n),
    .diag1_i(d1), .diag0_i(d0), .ent_valid_o(valid), .ent_ready_i(ready),
    .ent_addr_o(e_addr), .ent_data_o(e_data), .ent_kind_o(e_kind),
    .ent_wr_cached_o(wrc), .ent_trig_err_o(terr), .ovf_cnt_o(ovf)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic trc_kind_e rd_type(input logic a1, input logic a0);
    if (!a1) return KIND_UNC;
    return a0 ? KIND_IFT : KIND_DLD;
  endfunction

  // diag pins flipped after ALE to prove latching (R4)
  task automatic ale_phase(input logic [27:0] h, input logic [1:0] l, input logic a1, input logic a0);
    hi = h; lo = l; d1 = a1; d0 = a0;
    cyc(2); ale_n = 1'b0; cyc(4); ale_n = 1'b1; cyc(1);
    d1 = ~a1; d0 = ~a0; cyc(3);
  endtask

  task automatic rd_burst(input logic [27:0] h, input logic [1:0] l, input logic a1,
                          input logic a0, input int n, input logic [31:0] base);
    trc_entry_t e;
    ale_phase(h, l, a1, a0);
    rd_n = 1'b0; cyc(3);
    for (int i = 0; i < n; i++) begin
      ad = base + 32'(i * 17); cyc(3);
      e.addr = {h, 2'(l + 2'(i)), 2'b00}; e.data = ad;
      e.kind = rd_type(a1, a0); e.wr_cached = 1'b0; e.trig_err = 1'b0;
      exp_q.push_back(e);
      rden_n = 1'b0; cyc(4); rden_n = 1'b1; cyc(3);
    end
    cyc(4); rd_n = 1'b1; cyc(4);
  endtask

  task automatic wr_cycle(input logic [27:0] h, input logic [1:0] l, input logic a1,
                          input logic a0, input logic [31:0] dat, input bit spur, input bit keep);
    trc_entry_t e;
    ale_phase(h, l, a1, a0);
    wr_n = 1'b0; ad = dat; cyc(3);
    if (spur) begin rden_n = 1'b0; cyc(4); rden_n = 1'b1; cyc(3); end
    cyc(3);
    e.addr = {h, l, 2'b00}; e.data = dat; e.kind = KIND_ST;
    e.wr_cached = a1; e.trig_err = spur;
    if (keep) exp_q.push_back(e);
    wr_n = 1'b1; cyc(6);
  endtask

  // scoreboard monitor: transfer at next posedge
  always @(negedge clk) begin
    if (rst_ni && valid && ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected entry", {32'h0, e_addr}, 64'h0);
      end else begin
        trc_entry_t x;
        x = exp_q.pop_front();
        chk(e_addr == x.addr, "R3 addr", 64'(e_addr), 64'(x.addr));
        chk(e_data == x.data, "R2 data", 64'(e_data), 64'(x.data));
        chk(e_kind == x.kind, "R4 kind", 64'(e_kind), 64'(x.kind));
        chk(wrc == x.wr_cached, "R5 wr_cached", 64'(wrc), 64'(x.wr_cached));
        chk(terr == x.trig_err, "R6 trig_err", 64'(terr), 64'(x.trig_err));
      end
    end
  end

  task automatic drain();
    int t = 0;
    while ((exp_q.size() != 0 || valid) && t < 2000) begin cyc(1); t++; end
    chk(exp_q.size() == 0, "R2 missing entries", 64'(exp_q.size()), 64'h0);
  endtask

  initial begin
    cyc(3); rst_ni = 1'b1; cyc(2);
    // R1
    chk(valid == 1'b0, "R1 valid after reset", 64'(valid), 64'h0);
    chk(ovf == 8'h0, "R1 ovf after reset", 64'(ovf), 64'h0);

    // R2 R3 R4: uncached burst, diag0 high but ignored
    rd_burst(28'h1FC0022, 2'd0, 1'b0, 1'b1, 4, 32'h1111_0000);
    drain();
    // R3 wrap from beat 2, cached data load; consumer stalls intermittently (R7)
    fork
      rd_burst(28'h0000ABC, 2'd2, 1'b1, 1'b0, 4, 32'hAAAA_5555);
      begin repeat (30) begin ready = 1'b0; cyc(5); ready = 1'b1; cyc(3); end end
    join
    ready = 1'b1;
    drain();
    // R4 fetch
    rd_burst(28'h1234567, 2'd1, 1'b1, 1'b1, 1, 32'hDEAD_BEEF);
    // R5 store, diag0 ignored, retained flag
    wr_cycle(28'h0BADF00, 2'd3, 1'b1, 1'b1, 32'h0F0F_1234, 1'b0, 1'b1);
    // R6 spurious read enable during store
    wr_cycle(28'h0000111, 2'd0, 1'b0, 1'b0, 32'h5555_AAAA, 1'b1, 1'b1);
    drain();

    // R8 overflow with stalled consumer; R7 hold
    ready = 1'b0;
    for (int i = 0; i < 18; i++)
      wr_cycle(28'(i + 32'h100), 2'(i), 1'(i), 1'b0, 32'hC000_0000 + 32'(i), 1'b0, i < 16);
    chk(ovf == 8'd2, "R8 overflow count", 64'(ovf), 64'd2);
    chk(valid == 1'b1, "R7 valid while stalled", 64'(valid), 64'h1);
    chk(e_data == 32'hC000_0000, "R7 oldest held", 64'(e_data), 64'hC000_0000);
    cyc(10);
    chk(e_data == 32'hC000_0000, "R7 entry stable", 64'(e_data), 64'hC000_0000);
    ready = 1'b1;
    drain();
    chk(ovf == 8'd2, "R8 count unchanged after drain", 64'(ovf), 64'd2);
    chk(valid == 1'b0, "R8 buffer empty", 64'(valid), 64'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule